// File: doc/BRIEF.md
# Pin-Multiplexed Reloading Timer/Counter

This block is a 16-bit down-counting timer/counter for a small microcontroller. Its count events come from one of four external input pins, picked by a 2-bit select, or from a power-of-two division of the system clock. Each external pin is brought into the clock domain through two flip-flops. An edge mode setting decides whether rising edges, falling edges, both edges or no edges count. When the count is zero, the next count event reloads it from a CPU-written reload value and flips an output line. That line can be routed to a dedicated pin.

A second pin, also chosen by a 2-bit select, acts as a capture enable. Each rising edge on it copies the live count into a capture register. The CPU reaches the block through an 8-bit register port with write and read strobes. The reload value is written high byte first and committed by the low-byte write. The capture register is read high byte first. That read freezes the matching low byte so the two halves form one coherent value.

Top module: `mux_timer_counter`

## Requirements
- R1: After reset the count, reload value, staged byte, capture register, frozen low byte, both configuration registers, the output toggle and the prescaler phase are all zero, so every register read returns 0 and `timerOut` is 0.
- R2: A write to address 3 only stages a byte and changes no observable behaviour. A write to address 2 loads {staged byte, written byte} into both the reload value and the count at that clock edge. Reads of addresses 2 and 3 return the low and high bytes of the committed reload value.
- R3: Each count event decrements a non-zero count by one. A count event at zero reloads the count from the reload value and inverts the output toggle, so a reload value N gives one toggle every N+1 events.
- R4: Address 0 holds the mode byte. Bits [1:0] select which of the four `extIn` pins supplies count edges; transitions on the other pins never count.
- R5: Mode byte bits [7:6] set the edge mode when counting from a pin: 0 counts nothing, 1 counts rising edges, 2 counts falling edges, 3 counts both.
- R6: A pin change sampled at clock edge k produces its count event at edge k+2 (two-flop synchronizer, one-cycle pulse per edge).
- R7: Mode byte bit 2 set selects the prescaler. Bits [5:3] = p then give one count event every 2^p cycles, on the cycles where the low p bits of a free-running 7-bit cycle counter (zero at reset) are all ones.
- R8: Address 1 holds the option byte (bits [7:4] read 0). Bits [1:0] select the capture-enable pin, and bit 2 enables capture. A synchronized rising edge on that pin copies the count held before that clock edge into the capture register.
- R9: A read of address 5 returns the capture high byte and freezes its low byte. A read of address 4 returns the frozen low byte. Addresses 6 and 7 read 0 and ignore writes.
- R10: `timerOut` equals the output toggle when option bit 3 is set and is 0 otherwise.
- R11: When a reload-value commit and a count event fall in the same cycle, the commit wins and the event is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (side effect on address 5) |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data, combinational from the address |
| extIn | input | 4 | Asynchronous external input pins |
| timerOut | output | 1 | Routed toggle output |

## Verification
A wrong count value stays hidden until the next reload. It then shows up as a `timerOut` edge that is early or late by the error, or as a wrong capture readback. The bench therefore runs a cycle-accurate model and compares `timerOut` and the read data on every clock. It also runs reload values small enough that a count error surfaces within a few cycles. A synchronizer or edge-mode error shifts or drops output toggles within one reload period. A broken byte staging or frozen low byte appears at the very next readback.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE    = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_OPTION  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOAD_LO = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LOAD_HI = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CAP_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CAP_HI  = 3'd5;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edgeMode_e;

  typedef struct packed {
    logic loadStage;
    logic loadCommit;
    logic countTick;
    logic capture;
    logic snapLow;
  } dpStrobe_t;
endpackage

// File: rtl/mtc_sync.sv
module mtc_sync #(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] asyncIn,
  output logic [NUM_IN-1:0] syncOut
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_pin
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= 1'b0;
        stage2 <= 1'b0;
      end else begin
        stage1 <= asyncIn[i];
        stage2 <= stage1;
      end
    end
    assign syncOut[i] = stage2;
  end
endmodule

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
  import mtc_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int PRE_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [BYTE_W-1:0]  regWdata,
  output logic [BYTE_W-1:0]  regRdata,
  input  logic [NUM_IN-1:0]  syncIn,
  input  logic [CNT_W-1:0]   loadVal,
  input  logic [CNT_W-1:0]   latchVal,
  input  logic [BYTE_W-1:0]  lowShadow,
  output dpStrobe_t          strobe,
  output logic               outEnable
);
  localparam int SEL_W = $clog2(NUM_IN);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic [SEL_W-1:0]  inSel;
  logic              useDivider;
  logic [PRE_W-1:0]  preSel;
  edgeMode_e         edgeMode;
  logic [SEL_W-1:0]  enSel;
  logic              capEnable;
  logic [NUM_IN-1:0] prevIn;
  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  preMask;
  logic              presTick;
  logic              pinRise;
  logic              pinFall;
  logic              pinTick;
  logic              modeWrite;

  assign modeWrite = regWr && (regAddr == ADDR_MODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSel      <= '0;
      useDivider <= 1'b0;
      preSel     <= '0;
      edgeMode   <= EDGE_OFF;
      enSel      <= '0;
      capEnable  <= 1'b0;
      outEnable  <= 1'b0;
      prevIn     <= '0;
      divCnt     <= '0;
    end else begin
      prevIn <= syncIn;
      divCnt <= divCnt + DIV_W'(1);
      if (modeWrite) begin
        inSel      <= regWdata[SEL_W-1:0];
        useDivider <= regWdata[2];
        preSel     <= regWdata[3 +: PRE_W];
        edgeMode   <= edgeMode_e'(regWdata[7:6]);
      end
      if (regWr && (regAddr == ADDR_OPTION)) begin
        enSel     <= regWdata[SEL_W-1:0];
        capEnable <= regWdata[2];
        outEnable <= regWdata[3];
      end
    end
  end

  // Prescaler: a tick whenever the low preSel bits of the free-running counter are all ones
  assign preMask  = (DIV_W'(1) << preSel) - DIV_W'(1);
  assign presTick = &(divCnt | ~preMask);

  assign pinRise = syncIn[inSel] & ~prevIn[inSel];
  assign pinFall = ~syncIn[inSel] & prevIn[inSel];

  always_comb begin
    unique case (edgeMode)
      EDGE_RISE: pinTick = pinRise;
      EDGE_FALL: pinTick = pinFall;
      EDGE_BOTH: pinTick = pinRise | pinFall;
      default:   pinTick = 1'b0;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.countTick  = useDivider ? presTick : pinTick;
    strobe.capture    = capEnable & syncIn[enSel] & ~prevIn[enSel];
    strobe.loadStage  = regWr && (regAddr == ADDR_LOAD_HI);
    strobe.loadCommit = regWr && (regAddr == ADDR_LOAD_LO);
    strobe.snapLow    = regRd && (regAddr == ADDR_CAP_HI);
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_MODE:    regRdata = {edgeMode, preSel, useDivider, inSel};
      ADDR_OPTION:  regRdata = {4'b0000, outEnable, capEnable, enSel};
      ADDR_LOAD_LO: regRdata = loadVal[BYTE_W-1:0];
      ADDR_LOAD_HI: regRdata = loadVal[CNT_W-1 -: BYTE_W];
      ADDR_CAP_LO:  regRdata = lowShadow;
      ADDR_CAP_HI:  regRdata = latchVal[CNT_W-1 -: BYTE_W];
      default:      regRdata = '0;
    endcase
  end

  // R7: a divided tick (ratio above 1) is never followed by another tick on the next cycle
  p_prescale_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (useDivider && preSel != '0 && strobe.countTick && !modeWrite) |=> !strobe.countTick);

  // R7: divide-by-one ticks on every cycle
  p_prescale_unity_r7: assert property (@(posedge clk) disable iff (!rstN)
    (useDivider && preSel == '0) |-> strobe.countTick);

  // R5: with edges disabled a pin never counts
  p_edge_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!useDivider && edgeMode == EDGE_OFF) |-> !strobe.countTick);
endmodule

// File: rtl/mtc_datapath.sv
module mtc_datapath
  import mtc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic              outEnable,
  output logic [CNT_W-1:0]  loadVal,
  output logic [CNT_W-1:0]  latchVal,
  output logic [BYTE_W-1:0] lowShadow,
  output logic              timerOut
);
  localparam int HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0]  hiStage;
  logic [CNT_W-1:0] count;
  logic             toggle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiStage   <= '0;
      loadVal   <= '0;
      count     <= '0;
      toggle    <= 1'b0;
      latchVal  <= '0;
      lowShadow <= '0;
    end else begin
      if (strobe.loadStage) hiStage <= wrByte[HI_W-1:0];
      if (strobe.loadCommit) begin
        loadVal <= {hiStage, wrByte};
        count   <= {hiStage, wrByte};
      end else if (strobe.countTick) begin
        if (count == '0) begin
          count  <= loadVal;
          toggle <= ~toggle;
        end else begin
          count <= count - CNT_W'(1);
        end
      end
      if (strobe.capture) latchVal  <= count;
      if (strobe.snapLow) lowShadow <= latchVal[BYTE_W-1:0];
    end
  end

  assign timerOut = outEnable & toggle;

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countTick && !strobe.loadCommit && count != '0)
      |=> (count == $past(count) - CNT_W'(1)) && $stable(toggle));

  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countTick && !strobe.loadCommit && count == '0)
      |=> (count == $past(loadVal)) && (toggle != $past(toggle)));

  p_commit_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCommit |=> (count == loadVal) && $stable(toggle));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countTick && !strobe.loadCommit) |=> $stable(count) && $stable(loadVal));

  p_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> latchVal == $past(count));

  p_snapshot_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.snapLow |=> lowShadow == $past(latchVal[BYTE_W-1:0]));
endmodule

// File: rtl/mux_timer_counter.sv
module mux_timer_counter
  import mtc_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int PRE_W  = 3,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  input  logic [NUM_IN-1:0] extIn,
  output logic              timerOut
);
  logic [NUM_IN-1:0] syncIn;
  dpStrobe_t         strobe;
  logic              outEnable;
  logic [CNT_W-1:0]  loadVal;
  logic [CNT_W-1:0]  latchVal;
  logic [BYTE_W-1:0] lowShadow;

  mtc_sync #(.NUM_IN(NUM_IN)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(extIn), .syncOut(syncIn)
  );

  mtc_ctrl #(.NUM_IN(NUM_IN), .PRE_W(PRE_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .syncIn(syncIn), .loadVal(loadVal),
    .latchVal(latchVal), .lowShadow(lowShadow), .strobe(strobe), .outEnable(outEnable)
  );

  mtc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrByte(regWdata), .outEnable(outEnable),
    .loadVal(loadVal), .latchVal(latchVal), .lowShadow(lowShadow), .timerOut(timerOut)
  );

  // R10: an unrouted output stays low
  p_out_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outEnable |-> !timerOut);
endmodule

// File: tb/mux_timer_counter_tb_top.sv
`timescale 1ns/1ps
module mux_timer_counter_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] extIn = '0;
  logic       timerOut;

  int checks = 0;
  int fails = 0;
  bit running = 0;
  bit done = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  mux_timer_counter dut_i (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .extIn(extIn), .timerOut(timerOut)
  );

  // Behavioural reference model
  int mS1[4], mS2[4], mS3[4];
  int mDiv, mMode, mOpt, mStage, mLoad, mCnt, mLatch, mShadow, mTog;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin mS1[i] = 0; mS2[i] = 0; mS3[i] = 0; end
      mDiv = 0; mMode = 0; mOpt = 0; mStage = 0; mLoad = 0;
      mCnt = 0; mLatch = 0; mShadow = 0; mTog = 0;
    end else begin
      int sel, pre, mode, en, mask, oldCnt, oldLatch;
      bit rise, fall, tick, cap;
      sel = mMode & 3;
      pre = (mMode >> 3) & 7;
      mode = (mMode >> 6) & 3;
      rise = (mS2[sel] == 1) && (mS3[sel] == 0);
      fall = (mS2[sel] == 0) && (mS3[sel] == 1);
      mask = (1 << pre) - 1;
      if ((mMode >> 2) & 1) tick = ((mDiv & mask) == mask);
      else tick = (mode == 1 && rise) || (mode == 2 && fall) || (mode == 3 && (rise || fall));
      en = mOpt & 3;
      cap = ((mOpt >> 2) & 1) && (mS2[en] == 1) && (mS3[en] == 0);
      oldCnt = mCnt;
      oldLatch = mLatch;
      if (regWr && regAddr == 2) begin
        mLoad = (mStage << 8) | int'(regWdata);
        mCnt = mLoad;
      end else if (tick) begin
        if (oldCnt == 0) begin mCnt = mLoad; mTog ^= 1; end
        else mCnt = oldCnt - 1;
      end
      if (regWr && regAddr == 3) mStage = int'(regWdata);
      if (regWr && regAddr == 0) mMode = int'(regWdata);
      if (regWr && regAddr == 1) mOpt = int'(regWdata) & 15;
      if (cap) mLatch = oldCnt;
      if (regRd && regAddr == 5) mShadow = oldLatch & 255;
      mDiv = (mDiv + 1) & 127;
      for (int i = 0; i < 4; i++) begin
        mS3[i] = mS2[i]; mS2[i] = mS1[i]; mS1[i] = int'(extIn[i]);
      end
    end
  end

  function automatic int expRd(input int a);
    case (a)
      0: return mMode;
      1: return mOpt;
      2: return mLoad & 255;
      3: return (mLoad >> 8) & 255;
      4: return mShadow;
      5: return (mLatch >> 8) & 255;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && running) begin
      check(curReq, "timerOut", int'(timerOut), ((mOpt >> 3) & 1) & mTog);
      check(curReq, "regRdata", int'(regRdata), expRd(int'(regAddr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    regWr = 1'b1; regAddr = 3'(a); regWdata = 8'(d);
    @(posedge clk); #1;
    regWr = 1'b0; regAddr = 3'd0;
  endtask

  task automatic rd(input int a, output int v);
    @(posedge clk); #1;
    regRd = 1'b1; regAddr = 3'(a);
    @(negedge clk);
    v = int'(regRdata);
    @(posedge clk); #1;
    regRd = 1'b0; regAddr = 3'd0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setPin(input int i, input bit v);
    @(posedge clk); #1;
    extIn[i] = v;
  endtask

  task automatic pulsePins(input int i, input int times, input int gap);
    for (int k = 0; k < times; k++) begin
      setPin(i, 1'b1); idle(gap);
      setPin(i, 1'b0); idle(gap);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v, hi, lo, expLatch;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state visible at every address and on the output
    check("R1", "timerOut after reset", int'(timerOut), 0);
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      check("R1", "register after reset", v, 0);
    end
    running = 1;

    // R10, R7, R3: route output, divide-by-one ticks, reload 3
    curReq = "R3";
    wr(1, 8'h08);
    wr(0, 8'h04);
    wr(3, 8'h00);
    wr(2, 8'h03);
    idle(30);

    // R2: a staged high byte alone changes nothing
    curReq = "R2";
    wr(3, 8'h01);
    idle(12);
    rd(2, v); check("R2", "load low unchanged by stage", v, 3);
    rd(3, v); check("R2", "load high unchanged by stage", v, 0);
    wr(3, 8'h00);
    wr(2, 8'h05);
    rd(2, v); check("R2", "load low committed", v, 5);

    // R11: commits while events arrive every cycle
    curReq = "R11";
    wr(2, 8'h02);
    wr(2, 8'h00);
    wr(2, 8'h01);
    idle(10);

    // R7: ratios 8 and 128
    curReq = "R7";
    wr(0, 8'h1C);
    idle(80);
    wr(2, 8'h01);
    wr(0, 8'h3C);
    idle(600);
    wr(0, 8'h2C);
    idle(200);

    // R4, R5, R6: pin 2 as source under each edge mode, others wiggling
    curReq = "R5";
    wr(2, 8'h01);
    wr(0, 8'h42);
    pulsePins(2, 6, 4);
    curReq = "R4";
    pulsePins(0, 4, 3);
    pulsePins(1, 4, 3);
    pulsePins(3, 4, 3);
    curReq = "R5";
    wr(0, 8'h82);
    pulsePins(2, 6, 4);
    wr(0, 8'hC2);
    pulsePins(2, 6, 4);
    wr(0, 8'h02);
    pulsePins(2, 4, 4);
    curReq = "R6";
    wr(0, 8'hC1);
    wr(2, 8'h00);
    pulsePins(1, 5, 1);
    pulsePins(1, 3, 2);

    // R8, R9: capture on pin 3 while counting down from 0x1234
    curReq = "R8";
    wr(1, 8'h0F);
    wr(0, 8'h04);
    wr(3, 8'h12);
    wr(2, 8'h34);
    idle(7);
    setPin(3, 1'b1);
    idle(6);
    setPin(3, 1'b0);
    idle(3);
    expLatch = mLatch;
    check("R8", "capture taken from running count", int'(expLatch < 32'h1234 && expLatch > 32'h1200), 1);
    curReq = "R9";
    rd(5, hi);
    setPin(3, 1'b1);
    idle(6);
    setPin(3, 1'b0);
    rd(4, lo);
    check("R9", "coherent capture high", hi, (expLatch >> 8) & 255);
    check("R9", "coherent capture low", lo, expLatch & 255);
    wr(6, 8'hFF);
    wr(7, 8'hAA);
    rd(6, v); check("R9", "unused address reads zero", v, 0);
    rd(7, v); check("R9", "unused address reads zero", v, 0);
    rd(0, v); check("R9", "mode byte unaffected", v, 8'h04);

    // R10: unrouted output stays low while toggling continues
    curReq = "R10";
    wr(3, 8'h00);
    wr(2, 8'h02);
    wr(1, 8'h00);
    idle(20);
    check("R10", "timerOut while unrouted", int'(timerOut), 0);
    wr(1, 8'h08);
    idle(20);

    running = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule